// File: doc/BRIEF.md
# Flash Controller Register Interface

This block is the register front end for a small on-chip non-volatile store. The store itself is modelled as ordinary flip-flops: a main array divided into equal pages, plus a separate user-configuration area. Software controls it through a narrow register bus, and a second data port reads and writes the arrays by byte or by 32-bit word.

A two-bit mode register gates every change to the arrays. Mode 0 makes the arrays read-only. Mode 1 lets data-port writes land. Mode 2 arms three erase triggers: whole main array, whole user area, or the single page that contains a given byte address. Each erase completes in the clock edge that accepts it. For that reason the ready status never drops, and software may poll it or ignore it.

Register offsets on `regSel` are 0 ready status, 1 mode, 2 page erase, 3 erase main array and 4 erase user area. The arrays are not reset. A reset only returns the mode to read-only.

Top module: `flash_regif`

## Requirements
- R1: Reading register offset 0 (ready) returns 32'h0000_0001 in every mode, and the value is available combinationally on `regRdData`.
- R2: The mode register at offset 1 resets to 0 and reads back the low two bits last written to it. Offset 2, offset 3, offset 4 and the unused offsets 5 to 7 read as 0.
- R3: A data-port write changes an array word only while the mode is 1. Writes in mode 0 or mode 2 leave the word unchanged. A word write (`memSize`=1) stores all 32 bits of `memWrData` at word `memAddr[..:2]` of the area that `memUser` selects (0 main, 1 user).
- R4: A byte write (`memSize`=0) replaces only byte lane `memAddr[1:0]` (lane 0 = bits 7:0) with `memWrData[7:0]`. A byte read returns that lane zero-extended in bits 7:0.
- R5: Writing a value with bit 0 set to offset 3 in mode 2 sets every main-array word to 32'hFFFF_FFFF. The user area is left unchanged.
- R6: Writing a value with bit 0 set to offset 4 in mode 2 sets every user-area word to 32'hFFFF_FFFF. The main array is left unchanged.
- R7: Writing a byte address below the main-array size to offset 2 in mode 2 sets every word of the page that holds that address to 32'hFFFF_FFFF. All other pages are left unchanged.
- R8: Erase triggers are ignored in modes 0 and 1. The erase-all and erase-user triggers are also ignored when bit 0 of the written value is 0.
- R9: Reset leaves the contents of both arrays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the mode register |
| regSel | input | 3 | Register offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational register read data |
| memAddr | input | ADDR_W (11) | Byte address on the data port |
| memUser | input | 1 | 0 selects the main array, 1 the user area |
| memSize | input | 1 | 0 byte access, 1 word access |
| memWrEn | input | 1 | Data-port write strobe |
| memWrData | input | 32 | Data-port write data |
| memRdData | output | 32 | Combinational data-port read data |

## Verification
Four checks run on every cycle. The control must never issue more than one array strobe at a time. An accepted erase must leave the first and last words of its region at all-ones on the next edge. A word write must land at its address. The mode register must capture the written value. Only the scenarios can show what is left alone: writes and erases refused in the wrong mode, neighbouring pages and the other area surviving an erase, byte-lane isolation, and contents kept across a reset.

// File: rtl/flash_regif_pkg.sv
package flash_regif_pkg;

  typedef enum logic [2:0] {
    REG_READY      = 3'd0,
    REG_MODE       = 3'd1,
    REG_PAGE_ERASE = 3'd2,
    REG_ERASE_MAIN = 3'd3,
    REG_ERASE_USER = 3'd4
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_ERASE = 2'd2
  } mode_e;

  typedef struct packed {
    logic wrMain;
    logic wrUser;
    logic eraseMain;
    logic eraseUser;
    logic erasePage;
  } strobe_t;

  function automatic logic [31:0] mergeLane(input logic [31:0] oldWord,
                                            input logic [31:0] newData,
                                            input logic        isWord,
                                            input logic [1:0]  lane);
    logic [31:0] res;
    res = oldWord;
    if (isWord) res = newData;
    else res[lane*8 +: 8] = newData[7:0];
    return res;
  endfunction

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_regif_pkg::*;
#(
  parameter int MAIN_BYTES = 2048,
  parameter int PAGE_SHIFT = 10,
  parameter int PAGE_IDX_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            regSel,
  input  logic                  regWrEn,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic                  memUser,
  input  logic                  memWrEn,
  output strobe_t               strb,
  output logic [PAGE_IDX_W-1:0] pageIdx
);

  logic [1:0] cfgMode;
  logic       inRange;
  logic       eraseArmed;

  always_ff @(posedge clk) begin
    if (rst) cfgMode <= MODE_READ;
    else if (regWrEn && regSel == REG_MODE) cfgMode <= regWrData[1:0];
  end

  assign eraseArmed = regWrEn && (cfgMode == MODE_ERASE);
  assign inRange    = regWrData < 32'(MAIN_BYTES);
  assign pageIdx    = regWrData[PAGE_SHIFT +: PAGE_IDX_W];

  always_comb begin
    strb           = '0;
    strb.wrMain    = memWrEn && !memUser && (cfgMode == MODE_WRITE);
    strb.wrUser    = memWrEn &&  memUser && (cfgMode == MODE_WRITE);
    strb.eraseMain = eraseArmed && regSel == REG_ERASE_MAIN && regWrData[0];
    strb.eraseUser = eraseArmed && regSel == REG_ERASE_USER && regWrData[0];
    strb.erasePage = eraseArmed && regSel == REG_PAGE_ERASE && inRange;
  end

  always_comb begin
    case (regSel)
      REG_READY: regRdData = 32'h0000_0001;
      REG_MODE:  regRdData = {30'b0, cfgMode};
      default:   regRdData = 32'h0;
    endcase
  end

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regSel == REG_MODE) |=> cfgMode == $past(regWrData[1:0])); // R2

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_regif_pkg::*;
#(
  parameter int MAIN_WORDS = 512,
  parameter int USER_WORDS = 64,
  parameter int PAGE_WORDS = 256,
  parameter int ADDR_W     = 11,
  parameter int PAGE_IDX_W = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic [PAGE_IDX_W-1:0] pageIdx,
  input  logic [ADDR_W-1:0]     memAddr,
  input  logic                  memUser,
  input  logic                  memSize,
  input  logic [31:0]           memWrData,
  output logic [31:0]           memRdData
);

  localparam int MAIN_IDX_W = ADDR_W - 2;
  localparam int USER_IDX_W = $clog2(USER_WORDS);
  localparam int WORD_SHIFT = $clog2(PAGE_WORDS);

  logic [31:0] mainMem [MAIN_WORDS];
  logic [31:0] userMem [USER_WORDS];

  logic [MAIN_IDX_W-1:0] mainIdx;
  logic [USER_IDX_W-1:0] userIdx;
  logic [1:0]            lane;
  logic [31:0]           rdWord;
  logic [MAIN_IDX_W-1:0] pageFirst, pageLast;

  assign mainIdx   = memAddr[ADDR_W-1:2];
  assign userIdx   = memAddr[USER_IDX_W+1:2];
  assign lane      = memAddr[1:0];
  assign pageFirst = {pageIdx, {WORD_SHIFT{1'b0}}};
  assign pageLast  = {pageIdx, {WORD_SHIFT{1'b1}}};

  for (genvar w = 0; w < MAIN_WORDS; w++) begin : g_main
    localparam int PAGE_OF = w / PAGE_WORDS;
    always_ff @(posedge clk) begin
      if (strb.eraseMain)
        mainMem[w] <= '1;
      else if (strb.erasePage && int'(pageIdx) == PAGE_OF)
        mainMem[w] <= '1;
      else if (strb.wrMain && int'(mainIdx) == w)
        mainMem[w] <= mergeLane(mainMem[w], memWrData, memSize, lane);
    end
  end

  for (genvar u = 0; u < USER_WORDS; u++) begin : g_user
    always_ff @(posedge clk) begin
      if (strb.eraseUser)
        userMem[u] <= '1;
      else if (strb.wrUser && int'(userIdx) == u)
        userMem[u] <= mergeLane(userMem[u], memWrData, memSize, lane);
    end
  end

  assign rdWord    = memUser ? userMem[userIdx] : mainMem[mainIdx];
  assign memRdData = memSize ? rdWord : {24'b0, rdWord[lane*8 +: 8]};

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb)); // R8
  AST_MAIN_FILL: assert property (@(posedge clk) disable iff (rst)
    strb.eraseMain |=> (mainMem[0] == '1 && mainMem[MAIN_WORDS-1] == '1)); // R5
  AST_USER_FILL: assert property (@(posedge clk) disable iff (rst)
    strb.eraseUser |=> (userMem[0] == '1 && userMem[USER_WORDS-1] == '1)); // R6
  AST_PAGE_FILL: assert property (@(posedge clk) disable iff (rst)
    strb.erasePage |=> (mainMem[$past(pageFirst)] == '1 &&
                        mainMem[$past(pageLast)] == '1)); // R7
  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (strb.wrMain && memSize) |=> mainMem[$past(mainIdx)] == $past(memWrData)); // R3

endmodule

// File: rtl/flash_regif.sv
module flash_regif
  import flash_regif_pkg::*;
#(
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_PAGES  = 2,
  parameter int USER_WORDS = 64,
  localparam int MAIN_BYTES = PAGE_BYTES * NUM_PAGES,
  localparam int ADDR_W     = $clog2(MAIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regSel,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memUser,
  input  logic              memSize,
  input  logic              memWrEn,
  input  logic [31:0]       memWrData,
  output logic [31:0]       memRdData
);

  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int MAIN_WORDS = PAGE_WORDS * NUM_PAGES;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int PAGE_IDX_W = $clog2(NUM_PAGES);

  strobe_t               strb;
  logic [PAGE_IDX_W-1:0] pageIdx;

  flash_ctrl #(
    .MAIN_BYTES(MAIN_BYTES), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_IDX_W(PAGE_IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memUser(memUser),
    .memWrEn(memWrEn), .strb(strb), .pageIdx(pageIdx)
  );

  flash_store #(
    .MAIN_WORDS(MAIN_WORDS), .USER_WORDS(USER_WORDS), .PAGE_WORDS(PAGE_WORDS),
    .ADDR_W(ADDR_W), .PAGE_IDX_W(PAGE_IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .strb(strb), .pageIdx(pageIdx), .memAddr(memAddr),
    .memUser(memUser), .memSize(memSize), .memWrData(memWrData),
    .memRdData(memRdData)
  );

endmodule

// File: tb/flash_regif_tb.sv
module flash_regif_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int WATCHDOG   = 20000;

  localparam logic [1:0] OP_REGW = 2'd0, OP_REGR = 2'd1,
                         OP_MEMW = 2'd2, OP_MEMR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        user;
    logic        size;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h2,        32'h0,        4'd2},
    '{OP_REGW, 1'b0, 1'b0, 16'h3,   32'h1,        32'h0,        4'd5},
    '{OP_REGW, 1'b0, 1'b0, 16'h4,   32'h1,        32'h0,        4'd6},
    '{OP_MEMR, 1'b0, 1'b1, 16'h0,   32'h0,        32'hFFFFFFFF, 4'd5},
    '{OP_MEMR, 1'b1, 1'b1, 16'h0,   32'h0,        32'hFFFFFFFF, 4'd6},
    '{OP_REGR, 1'b0, 1'b0, 16'h0,   32'h0,        32'h1,        4'd1},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h1,        32'h0,        4'd2},
    '{OP_MEMW, 1'b0, 1'b1, 16'h10,  32'h12345678, 32'h0,        4'd3},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h12345678, 4'd3},
    '{OP_MEMW, 1'b0, 1'b0, 16'h11,  32'hFFFFFFAB, 32'h0,        4'd4},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h1234AB78, 4'd4},
    '{OP_MEMR, 1'b0, 1'b0, 16'h12,  32'h0,        32'h34,       4'd4},
    '{OP_MEMW, 1'b1, 1'b1, 16'h8,   32'hCAFEF00D, 32'h0,        4'd3},
    '{OP_MEMR, 1'b1, 1'b1, 16'h8,   32'h0,        32'hCAFEF00D, 4'd3},
    '{OP_REGR, 1'b0, 1'b0, 16'h1,   32'h0,        32'h1,        4'd2},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h0,        32'h0,        4'd2},
    '{OP_MEMW, 1'b0, 1'b1, 16'h10,  32'h0,        32'h0,        4'd3},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h1234AB78, 4'd3},
    '{OP_REGW, 1'b0, 1'b0, 16'h3,   32'h1,        32'h0,        4'd8},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h1234AB78, 4'd8},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h1,        32'h0,        4'd2},
    '{OP_MEMW, 1'b0, 1'b1, 16'h400, 32'h11111111, 32'h0,        4'd3},
    '{OP_MEMW, 1'b0, 1'b1, 16'h7FC, 32'h22222222, 32'h0,        4'd3},
    '{OP_MEMW, 1'b0, 1'b1, 16'h3FC, 32'h33333333, 32'h0,        4'd3},
    '{OP_REGW, 1'b0, 1'b0, 16'h4,   32'h1,        32'h0,        4'd8},
    '{OP_MEMR, 1'b1, 1'b1, 16'h8,   32'h0,        32'hCAFEF00D, 4'd8},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h2,        32'h0,        4'd2},
    '{OP_MEMW, 1'b0, 1'b1, 16'h20,  32'h5,        32'h0,        4'd3},
    '{OP_MEMR, 1'b0, 1'b1, 16'h20,  32'h0,        32'hFFFFFFFF, 4'd3},
    '{OP_REGW, 1'b0, 1'b0, 16'h2,   32'h500,      32'h0,        4'd7},
    '{OP_MEMR, 1'b0, 1'b1, 16'h400, 32'h0,        32'hFFFFFFFF, 4'd7},
    '{OP_MEMR, 1'b0, 1'b1, 16'h7FC, 32'h0,        32'hFFFFFFFF, 4'd7},
    '{OP_MEMR, 1'b0, 1'b1, 16'h3FC, 32'h0,        32'h33333333, 4'd7},
    '{OP_REGW, 1'b0, 1'b0, 16'h3,   32'h0,        32'h0,        4'd8},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h1234AB78, 4'd8},
    '{OP_REGW, 1'b0, 1'b0, 16'h4,   32'h1,        32'h0,        4'd6},
    '{OP_MEMR, 1'b1, 1'b1, 16'h8,   32'h0,        32'hFFFFFFFF, 4'd6},
    '{OP_MEMR, 1'b0, 1'b1, 16'h10,  32'h0,        32'h1234AB78, 4'd6},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h1,        32'h0,        4'd2},
    '{OP_MEMW, 1'b1, 1'b1, 16'h8,   32'hCAFEF00D, 32'h0,        4'd3},
    '{OP_REGW, 1'b0, 1'b0, 16'h1,   32'h2,        32'h0,        4'd2},
    '{OP_REGW, 1'b0, 1'b0, 16'h3,   32'h1,        32'h0,        4'd5},
    '{OP_MEMR, 1'b0, 1'b1, 16'h3FC, 32'h0,        32'hFFFFFFFF, 4'd5},
    '{OP_MEMR, 1'b1, 1'b1, 16'h8,   32'h0,        32'hCAFEF00D, 4'd5}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        regSel = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [ADDR_W-1:0] memAddr = '0;
  logic              memUser = 1'b0;
  logic              memSize = 1'b1;
  logic              memWrEn = 1'b0;
  logic [31:0]       memWrData = '0;
  logic [31:0]       memRdData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_regif u_dut (
    .clk(clk), .rst(rst), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memAddr(memAddr),
    .memUser(memUser), .memSize(memSize), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  task automatic compare(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [2:0] sel, input logic [31:0] exp,
                          input string tag);
    @(negedge clk);
    regSel = sel;
    #1 compare(tag, regRdData, exp);
  endtask

  task automatic memWrite(input logic user, input logic size,
                          input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    memUser = user; memSize = size; memAddr = a[ADDR_W-1:0];
    memWrData = d; memWrEn = 1'b1;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic memCheck(input logic user, input logic size,
                          input logic [15:0] a, input logic [31:0] exp,
                          input string tag);
    @(negedge clk);
    memUser = user; memSize = size; memAddr = a[ADDR_W-1:0];
    #1 compare(tag, memRdData, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state: R1 ready reads 1, R2 mode reads 0
    regCheck(3'd0, 32'h1, "R1 ready after reset");
    regCheck(3'd1, 32'h0, "R2 mode after reset");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_REGW: regWrite(VECS[i].addr[2:0], VECS[i].data);
        OP_REGR: regCheck(VECS[i].addr[2:0], VECS[i].expv, tag);
        OP_MEMW: memWrite(VECS[i].user, VECS[i].size, VECS[i].addr, VECS[i].data);
        default: memCheck(VECS[i].user, VECS[i].size, VECS[i].addr, VECS[i].expv, tag);
      endcase
    end

    // R1: ready holds 1 while mode is erase
    regCheck(3'd0, 32'h1, "R1 ready in erase mode");
    // R2: trigger and unused offsets read 0; mode 3 reads back
    regCheck(3'd3, 32'h0, "R2 erase-main reads 0");
    regCheck(3'd6, 32'h0, "R2 unused offset reads 0");
    regWrite(3'd1, 32'h3);
    regCheck(3'd1, 32'h3, "R2 mode readback 3");
    // R7: out-of-range page address ignored
    regWrite(3'd1, 32'h1);
    memWrite(1'b0, 1'b1, 16'h404, 32'h0BADF00D);
    regWrite(3'd1, 32'h2);
    regWrite(3'd2, 32'h800);
    memCheck(1'b0, 1'b1, 16'h404, 32'h0BADF00D, "R7 out-of-range page kept");
    // R4: byte read of lane 3
    memCheck(1'b0, 1'b0, 16'h407, 32'h0B, "R4 byte lane 3 read");
    // R9: reset keeps contents, returns mode to 0
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    regCheck(3'd1, 32'h0, "R2 mode cleared by reset");
    memCheck(1'b0, 1'b1, 16'h404, 32'h0BADF00D, "R9 main kept over reset");
    memCheck(1'b1, 1'b1, 16'h8, 32'hCAFEF00D, "R9 user kept over reset");

    finishRun();
  end

endmodule